// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block collects ten interrupt request lines plus a separate power-down request, holds each request in a pending latch until it is serviced, and presents the single most urgent eligible request to the processor core. Each source occupies a fixed priority slot. A slot is eligible only when its mask bit is set and the global enable is high. Power-down shares the top slot with the trip source and ignores both the mask and the enable. The block reports the slot number and the slot's fixed handler address. It also reports the address the core jumps to first: the three peripheral slots funnel through one shared entry point.

Software writes the whole mask register in one cycle. A write to the mask opens a blackout window in which nothing is presented. The window ends with the instruction-cycle strobe that follows the write. The core acknowledges the presented request with a one-cycle `irq_ack` pulse. That pulse clears only the slot that was being presented, and any other pending requests remain queued behind it.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, no request is pending, the mask register is all zeros, no blackout is active and `irq_valid` is 0.
- R2: A one-cycle request pulse on `req[k]` latches slot k as pending. In the next cycle, if the slot is eligible, `irq_valid` is 1, `irq_slot` is k and `irq_vec` gives the slot's handler address. The addresses by slot are 0:0x2C, 1:0x0C, 2:0x08, 3:0x10, 4:0x14, 5:0x18, 6:0x1C, 7:0x20, 8:0x24, 9:0x28.
- R3: Slot 0 has the highest priority and slot 9 the lowest. When several eligible slots are pending, only the lowest-numbered slot is presented and the others stay pending.
- R4: An `irq_ack` pulse while `irq_valid` is 1 clears only the presented slot. The next pending slot appears in the following cycle. An `irq_ack` pulse while `irq_valid` is 0 has no effect.
- R5: A pending slot whose bit in the mask register (bit k for slot k) is 0 is not presented. It stays pending and appears once the bit is set and any blackout has ended.
- R6: A `pd_req` pulse latches power-down, which is presented as slot 0 with address 0x2C regardless of the mask and the global enable. An acknowledge of slot 0 clears both power-down and the trip request.
- R7: While `glob_en` is 0, no maskable slot is presented. Power-down is still presented.
- R8: A mask write blocks every request, power-down included. The block starts in the cycle after the write and lasts up to and including the first later cycle in which `icyc` is 1. A strobe that arrives in the write cycle itself does not end the block.
- R9: `irq_core_vec` is 0x04 when slot 0, 1 or 2 is presented, and equals `irq_vec` for slots 3 to 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 10 | Request pulses, bit k for slot k |
| pd_req | input | 1 | Software power-down request pulse |
| mask_we | input | 1 | Mask register write strobe |
| mask_wdata | input | 10 | New mask value, bit k enables slot k |
| glob_en | input | 1 | Global enable for maskable slots |
| icyc | input | 1 | Instruction-cycle strobe |
| irq_ack | input | 1 | Acknowledge of the presented slot |
| irq_valid | output | 1 | A request is being presented |
| irq_slot | output | 4 | Presented slot number |
| irq_vec | output | 14 | Handler address of the presented slot |
| irq_core_vec | output | 14 | Address the core enters first |

## Verification
A pending bit that is set or cleared wrongly shows at the ports as soon as the mask and enable let that slot through. The symptom is a slot that vanishes after a lower-priority acknowledge, or a slot that reappears after its own acknowledge, and it shows in the cycle after the acknowledge. A wrong blackout flag shows as a presentation in the cycle right after a mask write, or as a stall that persists past the next strobe. A wrong priority order or a wrong address shows on the first sweep cycle that presents the affected slot. The sweeps cover every single slot and every pair of slots, so each of these faults shows within a few cycles of the stimulus that exposes it.

// File: rtl/irq_prio_pkg.sv
`timescale 1ns/1ps
package irq_prio_pkg;
    localparam int NSLOT     = 10;
    localparam int SLOT_W    = $clog2(NSLOT);
    localparam int N_PERIPH  = 3;
    localparam logic [7:0] CORE_ENTRY = 8'h04;

    typedef struct packed {
        logic [NSLOT-1:0] pend;
        logic             pd;
    } pend_state_t;

    typedef struct packed {
        logic [NSLOT-1:0] mask;
        logic             blk;
    } gate_state_t;

    function automatic logic [7:0] slot_vector(input logic [SLOT_W-1:0] s);
        logic [7:0] v;
        case (s)
            4'd0:    v = 8'h2C;
            4'd1:    v = 8'h0C;
            4'd2:    v = 8'h08;
            4'd3:    v = 8'h10;
            4'd4:    v = 8'h14;
            4'd5:    v = 8'h18;
            4'd6:    v = 8'h1C;
            4'd7:    v = 8'h20;
            4'd8:    v = 8'h24;
            4'd9:    v = 8'h28;
            default: v = 8'h00;
        endcase
        return v;
    endfunction
endpackage

// File: rtl/irq_pend_bank.sv
`timescale 1ns/1ps
module irq_pend_bank
    import irq_prio_pkg::*;
#(
    parameter int N  = NSLOT,
    parameter int SW = SLOT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic          pd_req,
    input  logic          clr_en,
    input  logic [SW-1:0] clr_slot,
    output logic [N-1:0]  pend,
    output logic          pd_pend
);
    pend_state_t st_d, st_q;

    // A request in the same cycle as a clear wins: the source asked again.
    always_comb begin
        st_d = st_q;
        if (clr_en) begin
            for (int i = 0; i < N; i++) begin
                if (clr_slot == SW'(i)) st_d.pend[i] = 1'b0;
            end
            if (clr_slot == '0) st_d.pd = 1'b0;
        end
        st_d.pend = st_d.pend | req;
        st_d.pd   = st_d.pd | pd_req;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend    = st_q.pend;
    assign pd_pend = st_q.pd;
endmodule

// File: rtl/irq_mask_gate.sv
`timescale 1ns/1ps
module irq_mask_gate
    import irq_prio_pkg::*;
#(
    parameter int N = NSLOT
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mask_we,
    input  logic [N-1:0] mask_wdata,
    input  logic         icyc,
    output logic [N-1:0] mask,
    output logic         blk
);
    gate_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (mask_we) begin
            st_d.mask = mask_wdata;
            st_d.blk  = 1'b1;
        end else if (icyc && st_q.blk) begin
            st_d.blk  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask = st_q.mask;
    assign blk  = st_q.blk;
endmodule

// File: rtl/irq_slot_select.sv
`timescale 1ns/1ps
module irq_slot_select
    import irq_prio_pkg::*;
#(
    parameter int N      = NSLOT,
    parameter int SW     = SLOT_W,
    parameter int ADDR_W = 14,
    parameter int NPER   = N_PERIPH
) (
    input  logic [N-1:0]      pend,
    input  logic              pd_pend,
    input  logic [N-1:0]      mask,
    input  logic              glob_en,
    input  logic              blk,
    output logic              valid,
    output logic [SW-1:0]     slot,
    output logic [ADDR_W-1:0] vec,
    output logic [ADDR_W-1:0] core_vec
);
    logic [N-1:0] elig;

    for (genvar g = 0; g < N; g++) begin : g_elig
        if (g == 0) begin : g_top
            assign elig[g] = !blk && ((pend[g] && mask[g] && glob_en) || pd_pend);
        end else begin : g_rest
            assign elig[g] = !blk && pend[g] && mask[g] && glob_en;
        end
    end

    always_comb begin
        slot = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (elig[i]) slot = SW'(i);
        end
        valid    = |elig;
        vec      = valid ? ADDR_W'(slot_vector(slot)) : '0;
        core_vec = vec;
        if (valid && (int'(slot) < NPER)) core_vec = ADDR_W'(CORE_ENTRY);
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
`timescale 1ns/1ps
module irq_prio_ctrl
    import irq_prio_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int N      = NSLOT,
    parameter int SW     = SLOT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      req,
    input  logic              pd_req,
    input  logic              mask_we,
    input  logic [N-1:0]      mask_wdata,
    input  logic              glob_en,
    input  logic              icyc,
    input  logic              irq_ack,
    output logic              irq_valid,
    output logic [SW-1:0]     irq_slot,
    output logic [ADDR_W-1:0] irq_vec,
    output logic [ADDR_W-1:0] irq_core_vec
);
    logic [N-1:0] pend;
    logic         pd_pend;
    logic [N-1:0] mask;
    logic         blk;
    logic         clr_en;

    assign clr_en = irq_ack && irq_valid;

    irq_pend_bank #(.N(N), .SW(SW)) u_pend (
        .clk(clk), .rst_n(rst_n), .req(req), .pd_req(pd_req),
        .clr_en(clr_en), .clr_slot(irq_slot),
        .pend(pend), .pd_pend(pd_pend)
    );

    irq_mask_gate #(.N(N)) u_gate (
        .clk(clk), .rst_n(rst_n), .mask_we(mask_we), .mask_wdata(mask_wdata),
        .icyc(icyc), .mask(mask), .blk(blk)
    );

    irq_slot_select #(.N(N), .SW(SW), .ADDR_W(ADDR_W), .NPER(N_PERIPH)) u_sel (
        .pend(pend), .pd_pend(pd_pend), .mask(mask), .glob_en(glob_en), .blk(blk),
        .valid(irq_valid), .slot(irq_slot), .vec(irq_vec), .core_vec(irq_core_vec)
    );
endmodule

// File: rtl/irq_prio_checker.sv
`timescale 1ns/1ps
module irq_prio_checker
    import irq_prio_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int N      = NSLOT,
    parameter int SW     = SLOT_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N-1:0]      req,
    input logic              mask_we,
    input logic              glob_en,
    input logic              irq_ack,
    input logic              irq_valid,
    input logic [SW-1:0]     irq_slot,
    input logic [ADDR_W-1:0] irq_vec,
    input logic [ADDR_W-1:0] irq_core_vec,
    input logic [N-1:0]      pend,
    input logic              pd_pend,
    input logic [N-1:0]      mask,
    input logic              blk
);
    // R8: a mask write always leads to a blocked cycle
    a_r8_write_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> (blk && !irq_valid));

    // R8: nothing is presented during a blackout
    a_r8_blackout_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        blk |-> !irq_valid);

    // R2: a presentation needs a pending source
    a_r2_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (pend[irq_slot] || pd_pend));

    // R5, R7: slots below the top are presented only when unmasked and enabled
    a_r5_mask_respected: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && irq_slot != '0) |-> (mask[irq_slot] && glob_en));

    // R6: pending power-down outside a blackout is always presented at the top slot
    a_r6_pd_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_pend && !blk) |-> (irq_valid && irq_slot == '0));

    // R4: an acknowledge removes the presented slot unless it is requested again
    a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && irq_ack && !req[irq_slot]) |=> !pend[$past(irq_slot)]);

    // R9: slots beyond the peripheral group enter the core at their own address
    a_r9_direct_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && int'(irq_slot) >= N_PERIPH) |-> (irq_core_vec == irq_vec));
endmodule

bind irq_prio_ctrl irq_prio_checker #(.ADDR_W(ADDR_W), .N(N), .SW(SW)) u_chk (
    .clk(clk), .rst_n(rst_n), .req(req), .mask_we(mask_we), .glob_en(glob_en),
    .irq_ack(irq_ack), .irq_valid(irq_valid), .irq_slot(irq_slot),
    .irq_vec(irq_vec), .irq_core_vec(irq_core_vec),
    .pend(pend), .pd_pend(pd_pend), .mask(mask), .blk(blk)
);

// File: tb/irq_prio_ctrl_test.sv
`timescale 1ns/1ps
module irq_prio_ctrl_test;
    localparam int N = 10;
    localparam int AW = 14;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  req = '0;
    logic          pd_req = 1'b0;
    logic          mask_we = 1'b0;
    logic [N-1:0]  mask_wdata = '0;
    logic          glob_en = 1'b0;
    logic          icyc = 1'b0;
    logic          irq_ack = 1'b0;
    logic          irq_valid;
    logic [3:0]    irq_slot;
    logic [AW-1:0] irq_vec;
    logic [AW-1:0] irq_core_vec;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_prio_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req(req), .pd_req(pd_req),
        .mask_we(mask_we), .mask_wdata(mask_wdata), .glob_en(glob_en),
        .icyc(icyc), .irq_ack(irq_ack), .irq_valid(irq_valid),
        .irq_slot(irq_slot), .irq_vec(irq_vec), .irq_core_vec(irq_core_vec)
    );

    function automatic int exp_vec(input int s);
        if (s == 0) return 'h2C;
        if (s <= 2) return 'h0C - 4 * (s - 1);
        return 'h10 + 4 * (s - 3);
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_out(input string rq, input bit ev, input int es);
        int ecore;
        #0.5;
        n_chk++;
        ecore = (es <= 2) ? 'h04 : exp_vec(es);
        if (irq_valid !== ev) begin
            n_fail++;
            $display("FAIL %s valid actual=%0b expected=%0b", rq, irq_valid, ev);
        end else if (ev && (int'(irq_slot) != es || int'(irq_vec) != exp_vec(es)
                            || int'(irq_core_vec) != ecore)) begin
            n_fail++;
            $display("FAIL %s slot/vec/core actual=%0d/%0h/%0h expected=%0d/%0h/%0h",
                     rq, irq_slot, irq_vec, irq_core_vec, es, exp_vec(es), ecore);
        end
    endtask

    task automatic pulse_req(input logic [N-1:0] r);
        req = r; tick(); req = '0;
    endtask

    task automatic ack();
        irq_ack = 1'b1; tick(); irq_ack = 1'b0;
    endtask

    task automatic write_mask(input logic [N-1:0] m, input bit end_blk);
        mask_we = 1'b1; mask_wdata = m; tick(); mask_we = 1'b0;
        if (end_blk) begin icyc = 1'b1; tick(); icyc = 1'b0; end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        glob_en = 1'b1;
        // R1: reset leaves mask zero, so a request must not show until unmasked
        expect_out("R1 reset idle", 0, 0);
        pulse_req(10'h020);
        expect_out("R1 mask zero after reset", 0, 0);
        write_mask('1, 1);
        expect_out("R1 pending kept from reset mask", 1, 5);
        ack();
        expect_out("R4 cleared", 0, 0);

        // R2, R9: every slot alone
        for (int k = 0; k < N; k++) begin
            pulse_req(N'(1) << k);
            expect_out("R2 single slot", 1, k);
            ack();
            expect_out("R4 single cleared", 0, 0);
        end

        // R3, R4: every pair of slots
        for (int i = 0; i < N; i++) begin
            for (int j = i + 1; j < N; j++) begin
                pulse_req((N'(1) << i) | (N'(1) << j));
                expect_out("R3 pair higher first", 1, i);
                ack();
                expect_out("R4 pair lower kept", 1, j);
                ack();
                expect_out("R4 pair drained", 0, 0);
            end
        end

        // R5, R8, R4: each slot masked, ack while idle ignored, then unmasked
        for (int k = 0; k < N; k++) begin
            write_mask(~(N'(1) << k), 1);
            pulse_req(N'(1) << k);
            expect_out("R5 masked hidden", 0, 0);
            ack();
            expect_out("R4 idle ack ignored", 0, 0);
            write_mask('1, 0);
            expect_out("R8 blackout after write", 0, 0);
            icyc = 1'b1; tick(); icyc = 1'b0;
            expect_out("R5 unmasked appears", 1, k);
            ack();
        end

        // R8: strobe in the write cycle does not end the blackout
        pulse_req(10'h200);
        expect_out("R8 timer shown", 1, 9);
        mask_we = 1'b1; mask_wdata = '1; icyc = 1'b1; tick();
        mask_we = 1'b0; icyc = 1'b0;
        expect_out("R8 strobe in write cycle", 0, 0);
        tick();
        expect_out("R8 held without strobe", 0, 0);
        icyc = 1'b1; tick(); icyc = 1'b0;
        expect_out("R8 released after strobe", 1, 9);
        ack();

        // R7: global enable
        glob_en = 1'b0;
        pulse_req(10'h010);
        expect_out("R7 enable low hides", 0, 0);
        glob_en = 1'b1;
        expect_out("R7 enable high shows", 1, 4);
        ack();

        // R6: power-down ignores mask and enable, shares the top slot with trip
        write_mask('0, 1);
        glob_en = 1'b0;
        pd_req = 1'b1; tick(); pd_req = 1'b0;
        expect_out("R6 power-down bypass", 1, 0);
        ack();
        expect_out("R6 power-down cleared", 0, 0);
        // R8: blackout also holds back power-down
        pd_req = 1'b1; req = 10'h001; tick(); pd_req = 1'b0; req = '0;
        expect_out("R6 pd with trip", 1, 0);
        write_mask('0, 0);
        expect_out("R8 blackout holds power-down", 0, 0);
        icyc = 1'b1; tick(); icyc = 1'b0;
        expect_out("R6 pd back after blackout", 1, 0);
        ack();
        glob_en = 1'b1;
        write_mask('1, 1);
        expect_out("R6 ack clears pd and trip", 0, 0);

        // R3: all slots at once drain in order
        pulse_req('1);
        for (int k = 0; k < N; k++) begin
            expect_out("R3 full drain order", 1, k);
            ack();
        end
        expect_out("R3 full drain empty", 0, 0);

        finish_run();
    end
endmodule